// File: doc/BRIEF.md
# Upper-Memory Shadow Steering Decoder

This block sits beside a memory controller and classifies every memory cycle that falls in the upper 256KB of the first megabyte (C0000h-FFFFFh). For each cycle it decides where the access goes. A cycle can go to local shadow DRAM, to the boot ROM chip select, or out to the expansion bus. A write can also be refused because the target shadow area is write-protected. The decision uses only the cycle's upper address bits, its direction and a set of static shadow-control fields, and it is presented one clock after the cycle is offered.

The adapter segments C, D and E are each cut into 16KB granules, and every granule has its own shadow enable. Each of the three segments also has a write-protect bit. The E segment has a mode bit that hands the whole segment to the ROM chip select. The C segment has a fill mode for loading shadow RAM: reads come from the bus and writes land in DRAM. The F segment holds the system BIOS and has two modes. In split mode, reads come from ROM and writes go to DRAM. In locked mode, reads come from DRAM and writes are refused.

Top module: `shd_steer`

## Requirements
- R1: All four outputs are registered. A cycle offered with `cyc_valid` high on one rising edge shows its decision after that edge. After an edge where `cyc_valid` was low, and throughout reset, all outputs are 0.
- R2: For a valid cycle inside C0000h-FFFFFh, exactly one of `dram_sel`, `rom_cs`, `bus_sel` and `wr_inhibit` is 1.
- R3: `cyc_addr` carries A19..A14. A valid cycle with A19:A18 not equal to 11 (below C0000h) drives all outputs to 0.
- R4: A17:A16 select the segment: 00 is C, 01 is D, 10 is E and 11 is F. A15:A14 select the granule. Bit 4*seg+granule of `gran_en` enables shadowing, with C=0, D=1 and E=2. In C, D, and E when `e_shadow_en` is 1, a cycle to a granule whose enable is 0 sets `bus_sel`, for both reads and writes.
- R5: In the D segment, a cycle to an enabled granule sets `dram_sel`. A write there with `seg_wp[1]`=1 sets `wr_inhibit` instead.
- R6: In the E segment with `e_shadow_en`=0, every cycle sets `rom_cs`, whatever the granule enables and write protection are.
- R7: In the E segment with `e_shadow_en`=1, a cycle to an enabled granule sets `dram_sel`. A write there with `seg_wp[2]`=1 sets `wr_inhibit` instead.
- R8: In the C segment with `c_fill_en`=0, a cycle to an enabled granule sets `dram_sel`. A write there with `seg_wp[0]`=1 sets `wr_inhibit` instead.
- R9: In the C segment with `c_fill_en`=1, a read of an enabled granule sets `bus_sel`. A write to an enabled granule sets `dram_sel`, or `wr_inhibit` when `seg_wp[0]`=1.
- R10: In the F segment with `bios_split`=1, reads set `rom_cs` and writes set `dram_sel`.
- R11: In the F segment with `bios_split`=0, reads set `dram_sel` and writes set `wr_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_valid | input | 1 | A memory cycle is offered this clock |
| cyc_addr | input | 6 | Address bits A19..A14 of the cycle |
| cyc_write | input | 1 | 1 for a write, 0 for a read |
| gran_en | input | 12 | Per-16KB shadow enables, C granules in bits 3:0, D in 7:4, E in 11:8 |
| seg_wp | input | 3 | Write protect for C (bit 0), D (bit 1), E (bit 2) |
| e_shadow_en | input | 1 | 0 gives the E segment to ROM, 1 uses its granule enables |
| c_fill_en | input | 1 | C segment fill mode: reads from bus, writes to DRAM |
| bios_split | input | 1 | F segment: 1 reads ROM and writes DRAM, 0 uses DRAM with writes refused |
| dram_sel | output | 1 | Cycle goes to shadow DRAM |
| rom_cs | output | 1 | Cycle goes to the ROM chip select |
| bus_sel | output | 1 | Cycle goes to the expansion bus |
| wr_inhibit | output | 1 | Write refused by write protection |

## Verification
The bench builds the block with its default granule width of two bits, which gives four 16KB granules per segment and 64 address codes in total. That configuration is small enough to drive every address code in both directions under each of several dozen control settings. These settings include all-zero and all-one settings and a pseudo-random spread. Every mode combination of the E, C and F segments is therefore met against every granule, including protected, unprotected, enabled and disabled granules. An idle cycle is also placed after each setting, so the return of the outputs to zero is exercised repeatedly.

// File: rtl/shd_pkg.sv
package shd_pkg;

    // Number of shadowable segments (C, D, E) and granule index width
    localparam int SHD_SEGS   = 3;
    localparam int SHD_GRAN_W = 2;

    // Segment code taken from A17:A16; the order is decoded by neighbours
    typedef enum logic [1:0] {
        SEG_C = 2'd0,
        SEG_D = 2'd1,
        SEG_E = 2'd2,
        SEG_F = 2'd3
    } seg_e;

    // Steering decision, one bit per destination
    typedef struct packed {
        logic dram;
        logic rom;
        logic bus;
        logic inhibit;
    } route_t;

endpackage

// File: rtl/shd_addr_split.sv
module shd_addr_split
    import shd_pkg::*;
#(
    parameter  int GRAN_W = SHD_GRAN_W,
    localparam int ADDR_W = GRAN_W + 4,
    localparam int NGRAN  = 1 << GRAN_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_region,
    output seg_e              seg,
    output logic [NGRAN-1:0]  gran_oh
);

    // Upper region: both top address bits set
    assign in_region = &addr[ADDR_W-1 -: 2];
    assign seg       = seg_e'(addr[ADDR_W-3 -: 2]);

    for (genvar g = 0; g < NGRAN; g++) begin : g_gran
        assign gran_oh[g] = (addr[GRAN_W-1:0] == GRAN_W'(g));
    end

endmodule

// File: rtl/shd_gran_select.sv
module shd_gran_select
    import shd_pkg::*;
#(
    parameter int NSEG  = SHD_SEGS,
    parameter int NGRAN = 1 << SHD_GRAN_W
) (
    input  logic [NSEG*NGRAN-1:0] en,
    input  seg_e                  seg,
    input  logic [NGRAN-1:0]      gran_oh,
    input  logic [NSEG-1:0]       wp,
    output logic                  gran_hit,
    output logic                  seg_prot
);

    logic [NSEG-1:0] seg_match;
    logic [NSEG-1:0] hit_vec;
    logic [NSEG-1:0] prot_vec;

    for (genvar s = 0; s < NSEG; s++) begin : g_seg
        assign seg_match[s] = (seg == seg_e'(2'(s)));
        assign hit_vec[s]   = seg_match[s] && |(en[s*NGRAN +: NGRAN] & gran_oh);
        assign prot_vec[s]  = seg_match[s] && wp[s];
    end

    assign gran_hit = |hit_vec;
    assign seg_prot = |prot_vec;

endmodule

// File: rtl/shd_route.sv
module shd_route
    import shd_pkg::*;
(
    input  logic   in_region,
    input  seg_e   seg,
    input  logic   write,
    input  logic   gran_hit,
    input  logic   seg_prot,
    input  logic   e_shadow_en,
    input  logic   c_fill_en,
    input  logic   bios_split,
    output route_t route
);

    always_comb begin
        route = '0;
        if (in_region) begin
            unique case (seg)
                SEG_C: begin
                    if (!gran_hit)                 route.bus     = 1'b1;
                    else if (c_fill_en && !write)  route.bus     = 1'b1;
                    else if (write && seg_prot)    route.inhibit = 1'b1;
                    else                           route.dram    = 1'b1;
                end
                SEG_D: begin
                    if (!gran_hit)                 route.bus     = 1'b1;
                    else if (write && seg_prot)    route.inhibit = 1'b1;
                    else                           route.dram    = 1'b1;
                end
                SEG_E: begin
                    if (!e_shadow_en)              route.rom     = 1'b1;
                    else if (!gran_hit)            route.bus     = 1'b1;
                    else if (write && seg_prot)    route.inhibit = 1'b1;
                    else                           route.dram    = 1'b1;
                end
                SEG_F: begin
                    if (bios_split) begin
                        if (write)                 route.dram    = 1'b1;
                        else                       route.rom     = 1'b1;
                    end else begin
                        if (write)                 route.inhibit = 1'b1;
                        else                       route.dram    = 1'b1;
                    end
                end
                default:                           route = '0;
            endcase
        end
    end

endmodule

// File: rtl/shd_steer.sv
module shd_steer
    import shd_pkg::*;
#(
    parameter  int GRAN_W = SHD_GRAN_W,
    localparam int NSEG   = SHD_SEGS,
    localparam int NGRAN  = 1 << GRAN_W,
    localparam int ADDR_W = GRAN_W + 4,
    localparam int EN_W   = NSEG * NGRAN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_valid,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_write,
    input  logic [EN_W-1:0]   gran_en,
    input  logic [NSEG-1:0]   seg_wp,
    input  logic              e_shadow_en,
    input  logic              c_fill_en,
    input  logic              bios_split,
    output logic              dram_sel,
    output logic              rom_cs,
    output logic              bus_sel,
    output logic              wr_inhibit
);

    typedef struct packed {
        route_t route;
    } state_t;

    logic              in_region;
    seg_e              seg;
    logic [NGRAN-1:0]  gran_oh;
    logic              gran_hit;
    logic              seg_prot;
    route_t            route_c;
    state_t            state_d;
    state_t            state_q;

    shd_addr_split #(.GRAN_W(GRAN_W)) addr_split_i (
        .addr      (cyc_addr),
        .in_region (in_region),
        .seg       (seg),
        .gran_oh   (gran_oh)
    );

    shd_gran_select #(.NSEG(NSEG), .NGRAN(NGRAN)) gran_select_i (
        .en       (gran_en),
        .seg      (seg),
        .gran_oh  (gran_oh),
        .wp       (seg_wp),
        .gran_hit (gran_hit),
        .seg_prot (seg_prot)
    );

    shd_route route_i (
        .in_region   (in_region),
        .seg         (seg),
        .write       (cyc_write),
        .gran_hit    (gran_hit),
        .seg_prot    (seg_prot),
        .e_shadow_en (e_shadow_en),
        .c_fill_en   (c_fill_en),
        .bios_split  (bios_split),
        .route       (route_c)
    );

    always_comb begin
        state_d = '0;
        if (cyc_valid) begin
            state_d.route = route_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dram_sel   = state_q.route.dram;
    assign rom_cs     = state_q.route.rom;
    assign bus_sel    = state_q.route.bus;
    assign wr_inhibit = state_q.route.inhibit;

    // R2
    route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dram_sel, rom_cs, bus_sel, wr_inhibit}));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |=> !(dram_sel || rom_cs || bus_sel || wr_inhibit));

    // R3
    low_addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !(&cyc_addr[ADDR_W-1 -: 2]))
        |=> !(dram_sel || rom_cs || bus_sel || wr_inhibit));

    // R2
    inhibit_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && !cyc_write) |=> !wr_inhibit);

    // R6
    e_rom_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr[ADDR_W-1 -: 4] == 4'b1110) && !e_shadow_en)
        |=> rom_cs);

    // R10
    bios_split_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr[ADDR_W-1 -: 4] == 4'b1111) && bios_split && !cyc_write)
        |=> rom_cs);

    // R11
    bios_locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr[ADDR_W-1 -: 4] == 4'b1111) && !bios_split && cyc_write)
        |=> wr_inhibit);

    // R4
    gran_off_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && (cyc_addr[ADDR_W-1 -: 4] == 4'b1101) && (gran_en == '0))
        |=> bus_sel);

endmodule

// File: tb/shd_steer_tb_top.sv
module shd_steer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_valid = 1'b0;
    logic [5:0]  cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic [11:0] gran_en = '0;
    logic [2:0]  seg_wp = '0;
    logic        e_shadow_en = 1'b0;
    logic        c_fill_en = 1'b0;
    logic        bios_split = 1'b0;
    logic        dram_sel, rom_cs, bus_sel, wr_inhibit;

    int errors = 0;
    int checks = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    shd_steer dut_i (
        .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_addr(cyc_addr),
        .cyc_write(cyc_write), .gran_en(gran_en), .seg_wp(seg_wp),
        .e_shadow_en(e_shadow_en), .c_fill_en(c_fill_en), .bios_split(bios_split),
        .dram_sel(dram_sel), .rom_cs(rom_cs), .bus_sel(bus_sel), .wr_inhibit(wr_inhibit)
    );

    // Expected {dram, rom, bus, inhibit}, derived from the full 20-bit address
    function automatic logic [3:0] expect_route(input logic [5:0] a, input logic wr);
        int unsigned full = int'(a) << 14;
        int unsigned off, sg, gr;
        if (full < 32'hC0000) return 4'b0000;
        off = full - 32'hC0000;
        sg  = off / 32'h10000;
        gr  = (off % 32'h10000) / 32'h4000;
        if (sg == 3) begin
            if (bios_split) return wr ? 4'b1000 : 4'b0100;
            return wr ? 4'b0001 : 4'b1000;
        end
        if (sg == 2 && !e_shadow_en) return 4'b0100;
        if (!gran_en[sg*4 + gr]) return 4'b0010;
        if (sg == 0 && c_fill_en && !wr) return 4'b0010;
        if (wr && seg_wp[sg]) return 4'b0001;
        return 4'b1000;
    endfunction

    function automatic string tag_of(input logic [5:0] a, input logic wr);
        int unsigned sg;
        if (a[5:4] != 2'b11) return "R3";
        sg = int'(a[3:2]);
        if (sg == 3) return bios_split ? "R10" : "R11";
        if (sg == 2 && !e_shadow_en) return "R6";
        if (!gran_en[sg*4 + int'(a[1:0])]) return "R4";
        if (sg == 1) return "R5";
        if (sg == 2) return "R7";
        if (c_fill_en) return "R9";
        return (wr && seg_wp[0]) ? "R8" : "R8";
    endfunction

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] act = {dram_sel, rom_cs, bus_sel, wr_inhibit};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h wr=%b act=%b exp=%b", tag, cyc_addr, cyc_write, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        int unsigned seed = 32'h1234_5678;
        logic [17:0] cfg;
        repeat (3) @(posedge clk);
        #1 check(4'b0000, "R1");
        @(negedge clk) rst_n = 1'b1;
        for (int c = 0; c < 48; c++) begin
            if (c == 0)      cfg = '0;
            else if (c == 1) cfg = '1;
            else begin
                seed = seed * 32'd1103515245 + 32'd12345;
                cfg  = seed[29:12];
            end
            @(negedge clk);
            {bios_split, c_fill_en, e_shadow_en, seg_wp, gran_en} = cfg;
            for (int a = 0; a < 64; a++) begin
                for (int w = 0; w < 2; w++) begin
                    @(negedge clk);
                    cyc_valid = 1'b1;
                    cyc_addr  = 6'(a);
                    cyc_write = w[0];
                    @(posedge clk);
                    #1;
                    // R2: exactly one destination inside the region, none below it
                    check(expect_route(cyc_addr, cyc_write), tag_of(cyc_addr, cyc_write));
                end
            end
            @(negedge clk);
            cyc_valid = 1'b0;
            cyc_addr  = 6'h3F;
            @(posedge clk);
            #1 check(4'b0000, "R1");
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            summary();
            $finish;
        end
    end

endmodule